// File: doc/BRIEF.md
# Flash Write-Lock Register

This block holds the single lock bit that guards a flash memory. A CPU reaches it through an I/O port at address 14h. Writing the port changes the lock bit, but only when two conditions both hold. The code doing the write must be running from a privileged ROM page. An external unlock-sequence guard must also be granting the write. A write that fails either check is dropped, and the block raises a one-cycle violation pulse.

While the lock is set, two things happen:
- the enable for flash write and erase commands is held low;
- reads of the single protected certification page are blocked, and the read data bus returns all ones instead of the stored data.

A two-bit variant input selects one of four memory layouts. The variant decides which pages are privileged and which page is protected. On the two extended variants, reading the port returns the lock state.

Top module: `flash_wrlock_reg`

## Requirements
- R1: While reset is held and after its release, the lock is set: `flash_cmd_en` is 0.
- R2: An accepted write to port 14h with data 00h sets the lock, and with 01h clears it. The write is accepted when it comes from a privileged page with `seq_grant` high. The new state is visible on the outputs in the cycle after the clock edge that samples the write.
- R3: An accepted write uses data bit 0 only. Bit 0 = 0 locks and bit 0 = 1 unlocks, whatever the other bits hold.
- R4: A port 14h write issued while `exec_page` is not privileged leaves the lock unchanged. The next cycle carries a one-cycle `lock_viol` pulse.
- R5: A port 14h write issued with `seq_grant` low leaves the lock unchanged and raises `lock_viol` for one cycle.
- R6: The privileged pages for each `variant` encoding are:
  - 0: 1Ch, 1Dh, 1Fh
  - 1: 3Ch, 3Dh, 3Fh
  - 2: 7Ch, 7Dh, 7Fh
  - 3: 6Fh, 7Ch, 7Dh, 7Fh
- R7: `flash_cmd_en` is 1 exactly while the lock is clear.
- R8: While locked, a read whose `rd_page` is the protected page drives `rd_block` high and `rd_data` to FFh. The protected page is 1Eh for variant 0, 3Eh for variant 1, and 7Eh for variants 2 and 3. Any other read passes `flash_rdata` through unchanged.
- R9: On variants 2 and 3, a port 14h read (`io_rd` high) returns 00h when locked and 01h when unlocked.
- R10: On variants 0 and 1, and whenever no port 14h read is in progress, `port_rdata` is 00h.
- R11: A write to any address other than 14h does not change the lock and raises no `lock_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| variant | input | 2 | Memory layout select (0..3) |
| exec_page | input | PAGE_W | Page the executing code runs from |
| seq_grant | input | 1 | Grant from the unlock-sequence guard |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | DATA_W | I/O write data |
| port_rdata | output | DATA_W | I/O read data for the lock port |
| lock_viol | output | 1 | One-cycle pulse on a rejected lock write |
| flash_cmd_en | output | 1 | Enable for flash write/erase commands |
| rd_page | input | PAGE_W | Page of the current flash read |
| flash_rdata | input | DATA_W | Data from the flash array |
| rd_block | output | 1 | Protected-page read is being blocked |
| rd_data | output | DATA_W | Read data after blocking |

## Verification
The bench targets these corner cases, each paired with the failure it exposes:
- **Page 1Eh/3Eh/7Eh boundary.** Pages sitting next to the privileged sets, and the protected page itself, are not privileged. A design that decodes a privileged range too widely would accept writes from these pages.
- **Variant 3's extra page 6Fh.** A design that forgets it would reject a legal write and raise a false violation pulse.
- **Bit 0 only.** Data values such as FEh and 03h show whether the lock uses bit 0 alone or compares the full byte.
- **Missing grant from a privileged page.** This separates the two acceptance conditions.
- **Writes to neighbouring addresses.** These catch a partial address decode.
- **Reads of pages adjacent to the protected one, and reads after unlock.** These show whether blocking is tied to both the exact page and the lock state.

// File: rtl/flash_wrlock_reg.sv
module flash_wrlock_reg #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOCK_PORT = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        variant,
  input  logic [PAGE_W-1:0] exec_page,
  input  logic              seq_grant,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] port_rdata,
  output logic              lock_viol,
  output logic              flash_cmd_en,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              rd_block,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [PAGE_W-1:0] PG_1C = PAGE_W'(8'h1C);
  localparam logic [PAGE_W-1:0] PG_1D = PAGE_W'(8'h1D);
  localparam logic [PAGE_W-1:0] PG_1E = PAGE_W'(8'h1E);
  localparam logic [PAGE_W-1:0] PG_1F = PAGE_W'(8'h1F);
  localparam logic [PAGE_W-1:0] PG_3C = PAGE_W'(8'h3C);
  localparam logic [PAGE_W-1:0] PG_3D = PAGE_W'(8'h3D);
  localparam logic [PAGE_W-1:0] PG_3E = PAGE_W'(8'h3E);
  localparam logic [PAGE_W-1:0] PG_3F = PAGE_W'(8'h3F);
  localparam logic [PAGE_W-1:0] PG_6F = PAGE_W'(8'h6F);
  localparam logic [PAGE_W-1:0] PG_7C = PAGE_W'(8'h7C);
  localparam logic [PAGE_W-1:0] PG_7D = PAGE_W'(8'h7D);
  localparam logic [PAGE_W-1:0] PG_7E = PAGE_W'(8'h7E);
  localparam logic [PAGE_W-1:0] PG_7F = PAGE_W'(8'h7F);

  logic              locked;
  logic              priv;
  logic [PAGE_W-1:0] prot_page;

  always_comb begin
    unique case (variant)
      2'd0:    priv = (exec_page == PG_1C) || (exec_page == PG_1D) || (exec_page == PG_1F);
      2'd1:    priv = (exec_page == PG_3C) || (exec_page == PG_3D) || (exec_page == PG_3F);
      2'd2:    priv = (exec_page == PG_7C) || (exec_page == PG_7D) || (exec_page == PG_7F);
      default: priv = (exec_page == PG_6F) || (exec_page == PG_7C) ||
                      (exec_page == PG_7D) || (exec_page == PG_7F);
    endcase
  end

  always_comb begin
    unique case (variant)
      2'd0:    prot_page = PG_1E;
      2'd1:    prot_page = PG_3E;
      default: prot_page = PG_7E;
    endcase
  end

  wire port_hit = (io_addr == LOCK_PORT);
  wire wr_hit   = io_wr && port_hit;
  wire accept   = wr_hit && priv && seq_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      lock_viol <= 1'b0;
    end else begin
      lock_viol <= wr_hit && !accept;
      if (accept) locked <= ~io_wdata[0];
    end
  end

  assign flash_cmd_en = ~locked;
  assign rd_block     = locked && (rd_page == prot_page);
  assign rd_data      = rd_block ? {DATA_W{1'b1}} : flash_rdata;
  assign port_rdata   = (io_rd && port_hit && variant[1]) ? {{(DATA_W-1){1'b0}}, ~locked}
                                                          : {DATA_W{1'b0}};

endmodule

// File: rtl/flash_wrlock_chk.sv
module flash_wrlock_chk #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOCK_PORT = 8'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        variant,
  input logic              seq_grant,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] port_rdata,
  input logic              lock_viol,
  input logic              flash_cmd_en,
  input logic [DATA_W-1:0] flash_rdata,
  input logic              rd_block,
  input logic [DATA_W-1:0] rd_data
);

  logic rst_q = 1'b1;
  always_ff @(posedge clk) rst_q <= rst_n;

  always_ff @(negedge clk) begin
    if (!rst_n && !rst_q)
      assert_reset_locked_R1: assert (!flash_cmd_en);
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == LOCK_PORT && seq_grant) |=>
      (lock_viol || flash_cmd_en == $past(io_wdata[0])));

  assert_nogrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == LOCK_PORT && !seq_grant) |=> (lock_viol && $stable(flash_cmd_en)));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == LOCK_PORT) |=> (!lock_viol && $stable(flash_cmd_en)));

  assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_block |-> (!flash_cmd_en && rd_data == {DATA_W{1'b1}}));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_block |-> (rd_data == flash_rdata));

  assert_portrd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == LOCK_PORT && variant[1]) |->
      (port_rdata == {{(DATA_W-1){1'b0}}, flash_cmd_en}));

  assert_portrd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_addr == LOCK_PORT && variant[1]) |-> (port_rdata == '0));

endmodule

bind flash_wrlock_reg flash_wrlock_chk #(
  .DATA_W(DATA_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .LOCK_PORT(LOCK_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .variant(variant), .seq_grant(seq_grant),
  .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
  .port_rdata(port_rdata), .lock_viol(lock_viol), .flash_cmd_en(flash_cmd_en),
  .flash_rdata(flash_rdata), .rd_block(rd_block), .rd_data(rd_data)
);

// File: tb/test_flash_wrlock_reg.sv
module test_flash_wrlock_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] variant = 2'd0;
  logic [7:0] exec_page = 8'h00;
  logic       seq_grant = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] port_rdata;
  logic       lock_viol;
  logic       flash_cmd_en;
  logic [7:0] rd_page = 8'h00;
  logic [7:0] flash_rdata = 8'h00;
  logic       rd_block;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit exp_locked = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wrlock_reg i_flash_wrlock_reg (
    .clk(clk), .rst_n(rst_n), .variant(variant), .exec_page(exec_page),
    .seq_grant(seq_grant), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .port_rdata(port_rdata), .lock_viol(lock_viol),
    .flash_cmd_en(flash_cmd_en), .rd_page(rd_page), .flash_rdata(flash_rdata),
    .rd_block(rd_block), .rd_data(rd_data)
  );

  function automatic bit is_priv(input logic [1:0] v, input logic [7:0] p);
    case (v)
      2'd0:    return p == 8'h1C || p == 8'h1D || p == 8'h1F;
      2'd1:    return p == 8'h3C || p == 8'h3D || p == 8'h3F;
      2'd2:    return p == 8'h7C || p == 8'h7D || p == 8'h7F;
      default: return p == 8'h6F || p == 8'h7C || p == 8'h7D || p == 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] prot_of(input logic [1:0] v);
    return (v == 2'd0) ? 8'h1E : (v == 2'd1) ? 8'h3E : 8'h7E;
  endfunction

  function automatic logic [7:0] pick_priv(input logic [1:0] v, input int k);
    logic [7:0] base;
    base = (v == 2'd0) ? 8'h1C : (v == 2'd1) ? 8'h3C : 8'h7C;
    if (v == 2'd3 && k % 4 == 3) return 8'h6F;
    case (k % 3)
      0:       return base;
      1:       return base + 8'h01;
      default: return base + 8'h03;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] v, input logic [7:0] pg, input bit g,
                          input logic [7:0] addr, input logic [7:0] d, input string tag);
    bit acc, hit;
    @(negedge clk);
    variant = v; exec_page = pg; seq_grant = g; io_addr = addr; io_wdata = d; io_wr = 1'b1;
    hit = (addr == 8'h14);
    acc = hit && g && is_priv(v, pg);
    @(posedge clk);
    #1 io_wr = 1'b0;
    #1;
    if (acc) exp_locked = ~d[0];
    check({tag, " viol"}, {7'b0, lock_viol}, {7'b0, hit && !acc});
    check({tag, " cmd_en"}, {7'b0, flash_cmd_en}, {7'b0, ~exp_locked});
    @(posedge clk);
    #2 check({tag, " viol pulse ends"}, {7'b0, lock_viol}, 8'h00);
  endtask

  task automatic do_port_read(input logic [1:0] v, input string tag);
    @(negedge clk);
    variant = v; io_addr = 8'h14; io_rd = 1'b1;
    #1 check(tag, port_rdata, v[1] ? {7'b0, ~exp_locked} : 8'h00);
    io_rd = 1'b0;
  endtask

  task automatic do_mem_read(input logic [1:0] v, input logic [7:0] pg,
                             input logic [7:0] d, input string tag);
    bit blk;
    @(negedge clk);
    variant = v; rd_page = pg; flash_rdata = d;
    blk = exp_locked && (pg == prot_of(v));
    #1;
    check({tag, " block"}, {7'b0, rd_block}, {7'b0, blk});
    check({tag, " data"}, rd_data, blk ? 8'hFF : d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_0014;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2 check("R1 cmd_en in reset", {7'b0, flash_cmd_en}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R1 cmd_en after reset", {7'b0, flash_cmd_en}, 8'h00);
    do_port_read(2'd2, "R1 R9 port read after reset");
    do_mem_read(2'd2, 8'h7E, 8'h5A, "R1 R8 protected read after reset");

    for (int v = 0; v < 4; v++) begin
      do_write(2'(v), pick_priv(2'(v), 0), 1'b1, 8'h14, 8'h01, "R2 R6 unlock");
      do_port_read(2'(v), "R9 R10 port read unlocked");
      do_mem_read(2'(v), prot_of(2'(v)), 8'h33, "R8 protected read unlocked");
      do_write(2'(v), pick_priv(2'(v), 1), 1'b1, 8'h14, 8'h00, "R2 R6 lock");
      do_port_read(2'(v), "R9 R10 port read locked");
      do_mem_read(2'(v), prot_of(2'(v)), 8'h44, "R8 protected read locked");
      do_mem_read(2'(v), prot_of(2'(v)) + 8'h01, 8'h45, "R8 neighbour page not blocked");
      do_write(2'(v), prot_of(2'(v)), 1'b1, 8'h14, 8'h01, "R4 protected page not privileged");
      do_write(2'(v), pick_priv(2'(v), 2) + 8'h01, 1'b1, 8'h14, 8'h01, "R4 R6 page above set");
    end

    do_write(2'd3, 8'h6F, 1'b1, 8'h14, 8'h01, "R6 variant3 page 6F");
    do_write(2'd2, 8'h6F, 1'b1, 8'h14, 8'h00, "R4 R6 variant2 page 6F rejected");
    do_write(2'd3, 8'h7D, 1'b0, 8'h14, 8'h00, "R5 no grant");
    do_write(2'd3, 8'h7D, 1'b1, 8'h14, 8'hFE, "R3 FEh locks");
    do_write(2'd3, 8'h7D, 1'b1, 8'h14, 8'h03, "R3 03h unlocks");
    do_write(2'd3, 8'h7D, 1'b1, 8'h15, 8'h00, "R11 other address");
    do_write(2'd3, 8'h7D, 1'b1, 8'h04, 8'h00, "R11 address 04h");
    check("R7 cmd_en unlocked", {7'b0, flash_cmd_en}, 8'h01);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] v;
      logic [7:0] pg, addr;
      int sel;
      v = 2'($urandom_range(0, 3));
      sel = $urandom_range(0, 3);
      pg = (sel < 2) ? pick_priv(v, $urandom_range(0, 11)) : 8'($urandom_range(0, 255));
      addr = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'h14;
      do_write(v, pg, $urandom_range(0, 3) != 0, addr, 8'($urandom_range(0, 255)),
               "R2 R3 R4 R5 R11 random write");
      do_port_read(2'($urandom_range(0, 3)), "R9 R10 random port read");
      do_mem_read(v, ($urandom_range(0, 1) == 0) ? prot_of(v) : 8'($urandom_range(0, 255)),
                  8'($urandom_range(0, 255)), "R7 R8 random read");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule